// File: doc/BRIEF.md
# Timer/Watchdog with Shared Prescaler

This block combines an 8-bit up-counting timer and a watchdog counter. They share one 8-bit prescaler. A single assignment bit places the prescaler in front of either the timer or the watchdog, and a 3-bit ratio field picks the division. The counter that does not own the prescaler runs from its raw tick.

The timer counts one of two sources. The first is the internal instruction tick, which is the block clock divided by 2 or by 4. The second is the edges of an external pin, after a two-flop synchronizer. When the timer wraps from 0xFF to 0x00 it raises a sticky interrupt flag. Software can load the timer at any time.

The watchdog advances on pulses of a slow, independent oscillator tick. It keeps counting while the core is in sleep. When it times out while enabled, it issues a one-cycle reset request.

Top module: `tmr_wdt_top`

## Requirements
- R1: With `tmrSrcExt`=0, the instruction tick fires on cycles where a free 2-bit divider (reset to 0, +1 per clock) is odd when `clkDiv4`=0, or equals 3 when `clkDiv4`=1. Without the prescaler, the timer adds 1 per instruction tick.
- R2: While `sleep`=1, the divider holds and no instruction tick fires, so an internally clocked timer holds its value. The watchdog path keeps counting `wdtTick` pulses.
- R3: With `tmrSrcExt`=1, the pin passes two synchronizer flops. A pin level sampled at clock edge k that differs from the level sampled at edge k-1 increments the timer at edge k+2. This applies only for a rise when `tmrEdgeFall`=0, and only for a fall when `tmrEdgeFall`=1.
- R4: With `psaToWdt`=0, the prescaler counts source ticks. The timer increments when a source tick arrives while prescaler bits [r:0] are all ones, which gives a ratio of 2^(r+1), from 1:2 to 1:256, for `psRatio`=r.
- R5: With `psaToWdt`=1, the prescaler counts `wdtTick` pulses. The watchdog steps when a tick arrives while bits [r-1:0] are all ones, which gives a ratio of 2^r, from 1:1 to 1:128. The timer then takes every source tick.
- R6: `tmrWrEn` loads `tmrWrData` into the timer at that edge and overrides any increment. It also clears the prescaler.
- R7: A timer increment from 0xFF to 0x00 sets `ovfIntFlag`. The flag stays set until `intClr`, and a new overflow in the same cycle as `intClr` keeps it set.
- R8: The WDT_BITS-bit watchdog counter advances on each watchdog step while enabled. The step taken when the counter is all ones wraps it and drives `wdtRst` high for exactly the following cycle.
- R9: While `wdtEn`=0, the watchdog counter is held at zero and `wdtRst` stays low.
- R10: `wdtClr` clears the watchdog counter and the prescaler and suppresses a time-out in that cycle.
- R11: After reset, the timer, the interrupt flag and `wdtRst` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (oscillator) |
| rstN | input | 1 | Active-low synchronous reset |
| sleep | input | 1 | Core sleep; stops instruction ticks |
| clkDiv4 | input | 1 | 0: tick = clk/2, 1: tick = clk/4 |
| tmrSrcExt | input | 1 | 0: internal tick, 1: external pin edges |
| tmrEdgeFall | input | 1 | External edge: 0 rising, 1 falling |
| extPin | input | 1 | Asynchronous external timer input |
| psaToWdt | input | 1 | Prescaler owner: 0 timer, 1 watchdog |
| psRatio | input | 3 | Prescaler ratio select |
| wdtEn | input | 1 | Watchdog enable |
| wdtTick | input | 1 | Slow watchdog oscillator tick (one-cycle pulse) |
| wdtClr | input | 1 | Clear watchdog counter and prescaler |
| tmrWrEn | input | 1 | Timer write strobe |
| tmrWrData | input | 8 | Timer write value |
| intClr | input | 1 | Clear the overflow flag |
| tmrRdData | output | 8 | Current timer value |
| ovfIntFlag | output | 1 | Sticky timer overflow flag |
| wdtRst | output | 1 | One-cycle watchdog reset request |

## Verification
The hardest state to reach from the ports is a watchdog time-out that happens while the core sleeps, with the prescaler assigned to the watchdog. In that state the timer must freeze while the shared prescaler keeps moving. The bench reaches it with a phase that holds `sleep` for stretches of ten cycles while `wdtTick` pulses on every clock under a small watchdog width. A second phase makes `wdtClr` land on the exact step that would have wrapped the counter. Timer loads of 0xFE and 0xFF with random `intClr` force overflow and clear into the same cycle.

// File: rtl/tmr_wdt_pkg.sv
package tmr_wdt_pkg;

  // Strobes from the control to the datapath, valid for one clock each
  typedef struct packed {
    logic tmrLoad;   // load timer from write data
    logic srcTick;   // selected timer source tick (internal or synced edge)
    logic psClr;     // clear the shared prescaler
    logic wdtTick;   // raw slow oscillator tick
    logic wdtClr;    // clear watchdog counter
    logic wdtRun;    // watchdog enabled
    logic intClr;    // clear overflow flag
  } dpStrobes_t;

endpackage

// File: rtl/tmr_wdt_ctrl.sv
module tmr_wdt_ctrl
  import tmr_wdt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sleep,
  input  logic       clkDiv4,
  input  logic       tmrSrcExt,
  input  logic       tmrEdgeFall,
  input  logic       extPin,
  input  logic       tmrWrEn,
  input  logic       intClr,
  input  logic       wdtTick,
  input  logic       wdtClr,
  input  logic       wdtEn,
  output dpStrobes_t strb
);

  localparam int HIST_W = SYNC_STAGES + 1;

  // Instruction-cycle divider
  logic [1:0] divQ;
  logic       instrTick;

  always_ff @(posedge clk) begin
    if (!rstN)       divQ <= '0;
    else if (!sleep) divQ <= divQ + 2'd1;
  end

  always_comb begin
    if (sleep)        instrTick = 1'b0;
    else if (clkDiv4) instrTick = (divQ == 2'd3);
    else              instrTick = divQ[0];
  end

  // External input: synchronizer stages plus one history flop
  logic [HIST_W-1:0] syncQ;
  logic              syncNow;
  logic              syncPrev;
  logic              extEdge;

  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[HIST_W-2:0], extPin};
  end

  assign syncNow  = syncQ[SYNC_STAGES-1];
  assign syncPrev = syncQ[SYNC_STAGES];

  always_comb begin
    if (tmrEdgeFall) extEdge = syncPrev & ~syncNow;
    else             extEdge = ~syncPrev & syncNow;
  end

  always_comb begin
    strb.tmrLoad = tmrWrEn;
    strb.srcTick = tmrSrcExt ? extEdge : instrTick;
    strb.psClr   = tmrWrEn | wdtClr;
    strb.wdtTick = wdtTick;
    strb.wdtClr  = wdtClr;
    strb.wdtRun  = wdtEn;
    strb.intClr  = intClr;
  end

  // R1
  no_back2back_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    instrTick |=> !instrTick);

  // R2
  sleep_divider_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    sleep |=> divQ == $past(divQ));

endmodule

// File: rtl/tmr_wdt_dp.sv
module tmr_wdt_dp
  import tmr_wdt_pkg::*;
#(
  parameter int TMR_W    = 8,
  parameter int PS_W     = 8,
  parameter int WDT_BITS = 10,
  parameter int RSEL_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strb,
  input  logic              psaToWdt,
  input  logic [RSEL_W-1:0] psRatio,
  input  logic [TMR_W-1:0]  tmrWrData,
  output logic [TMR_W-1:0]  tmrQ,
  output logic              ovfQ,
  output logic              wdtRstQ
);

  logic [PS_W-1:0]     psCnt;
  logic [PS_W-1:0]     psMask;
  logic                psInc;
  logic                psHit;
  logic                tmrTick;
  logic                wdtStep;
  logic [WDT_BITS-1:0] wdtCnt;

  // Ratio mask: timer owner covers bits [r:0], watchdog owner bits [r-1:0]
  for (genvar g = 0; g < PS_W; g++) begin : g_mask
    assign psMask[g] = psaToWdt ? (g < int'(psRatio)) : (g <= int'(psRatio));
  end

  assign psInc   = psaToWdt ? strb.wdtTick : strb.srcTick;
  assign psHit   = psInc && ((psCnt & psMask) == psMask);
  assign tmrTick = psaToWdt ? strb.srcTick : psHit;
  assign wdtStep = psaToWdt ? psHit : strb.wdtTick;

  // Shared prescaler
  always_ff @(posedge clk) begin
    if (!rstN)           psCnt <= '0;
    else if (strb.psClr) psCnt <= '0;
    else if (psInc)      psCnt <= psCnt + 1'b1;
  end

  // Timer and overflow flag
  always_ff @(posedge clk) begin
    if (!rstN)             tmrQ <= '0;
    else if (strb.tmrLoad) tmrQ <= tmrWrData;
    else if (tmrTick)      tmrQ <= tmrQ + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                                   ovfQ <= 1'b0;
    else if (!strb.tmrLoad && tmrTick && &tmrQ)  ovfQ <= 1'b1;
    else if (strb.intClr)                        ovfQ <= 1'b0;
  end

  // Watchdog counter and reset request
  always_ff @(posedge clk) begin
    if (!rstN)                          wdtCnt <= '0;
    else if (!strb.wdtRun || strb.wdtClr) wdtCnt <= '0;
    else if (wdtStep)                   wdtCnt <= wdtCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) wdtRstQ <= 1'b0;
    else       wdtRstQ <= strb.wdtRun && !strb.wdtClr && wdtStep && (&wdtCnt);
  end

  // R7
  overflow_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.tmrLoad && tmrTick && &tmrQ) |=> ovfQ);

  // R6
  load_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.tmrLoad |=> (tmrQ == $past(tmrWrData)) && (psCnt == '0));

  // R8
  reset_pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdtRstQ |=> !wdtRstQ);

  // R9
  reset_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    wdtRstQ |-> $past(strb.wdtRun));

  // R10
  wdt_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wdtClr |=> (wdtCnt == '0) && (psCnt == '0) && !wdtRstQ);

  // R2
  sleep_timer_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.tmrLoad && !strb.srcTick) |=> tmrQ == $past(tmrQ));

endmodule

// File: rtl/tmr_wdt_top.sv
module tmr_wdt_top
  import tmr_wdt_pkg::*;
#(
  parameter int TMR_W       = 8,
  parameter int PS_W        = 8,
  parameter int WDT_BITS    = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sleep,
  input  logic                    clkDiv4,
  input  logic                    tmrSrcExt,
  input  logic                    tmrEdgeFall,
  input  logic                    extPin,
  input  logic                    psaToWdt,
  input  logic [$clog2(PS_W)-1:0] psRatio,
  input  logic                    wdtEn,
  input  logic                    wdtTick,
  input  logic                    wdtClr,
  input  logic                    tmrWrEn,
  input  logic [TMR_W-1:0]        tmrWrData,
  input  logic                    intClr,
  output logic [TMR_W-1:0]        tmrRdData,
  output logic                    ovfIntFlag,
  output logic                    wdtRst
);

  localparam int RSEL_W = $clog2(PS_W);

  dpStrobes_t strb;

  tmr_wdt_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rstN(rstN), .sleep(sleep), .clkDiv4(clkDiv4),
    .tmrSrcExt(tmrSrcExt), .tmrEdgeFall(tmrEdgeFall), .extPin(extPin),
    .tmrWrEn(tmrWrEn), .intClr(intClr), .wdtTick(wdtTick),
    .wdtClr(wdtClr), .wdtEn(wdtEn), .strb(strb)
  );

  tmr_wdt_dp #(.TMR_W(TMR_W), .PS_W(PS_W), .WDT_BITS(WDT_BITS), .RSEL_W(RSEL_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .psaToWdt(psaToWdt),
    .psRatio(psRatio), .tmrWrData(tmrWrData), .tmrQ(tmrRdData),
    .ovfQ(ovfIntFlag), .wdtRstQ(wdtRst)
  );

endmodule

// File: tb/test_tmr_wdt_top.sv
`timescale 1ns/1ps
module test_tmr_wdt_top;

  localparam int WB = 4;
  localparam int WATCHDOG_CYC = 200000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sleep = 0, div4 = 0, ext = 0, fall = 0, pin = 0, psaW = 1;
  logic [2:0] ratio = 0;
  logic       en = 0, wTick = 0, wClr = 0, wr = 0, iClr = 0;
  logic [7:0] wrData = 0;
  logic [7:0] tmrOut;
  logic       ovfOut, rstOut;

  int checkCnt = 0;
  int failCnt  = 0;

  // Reference state
  logic [1:0]    mDiv = 0;
  logic          mS1 = 0, mS2 = 0, mS3 = 0;
  logic [7:0]    mPs = 0, mTmr = 0;
  logic          mOvf = 0, mRst = 0;
  logic [WB-1:0] mWdt = 0;

  always #2 clk = ~clk;

  tmr_wdt_top #(.WDT_BITS(WB)) i_tmr_wdt_top (
    .clk(clk), .rstN(rstN), .sleep(sleep), .clkDiv4(div4), .tmrSrcExt(ext),
    .tmrEdgeFall(fall), .extPin(pin), .psaToWdt(psaW), .psRatio(ratio),
    .wdtEn(en), .wdtTick(wTick), .wdtClr(wClr), .tmrWrEn(wr),
    .tmrWrData(wrData), .intClr(iClr), .tmrRdData(tmrOut),
    .ovfIntFlag(ovfOut), .wdtRst(rstOut)
  );

  function automatic logic [7:0] ratioMask(input logic toWdt, input logic [2:0] r);
    int m;
    m = toWdt ? ((1 << r) - 1) : ((1 << (r + 1)) - 1);
    return m[7:0];
  endfunction

  // Advance the reference by one clock using the inputs now applied
  task automatic modelStep();
    logic instr, edgeDet, src, psInc, hit, tTick, wStep;
    logic [7:0] mask;
    instr   = !sleep && (div4 ? (mDiv == 2'd3) : mDiv[0]);
    edgeDet = fall ? (mS3 & ~mS2) : (~mS3 & mS2);
    src     = ext ? edgeDet : instr;
    mask    = ratioMask(psaW, ratio);
    psInc   = psaW ? wTick : src;
    hit     = psInc && ((mPs & mask) == mask);
    tTick   = psaW ? src : hit;
    wStep   = psaW ? hit : wTick;
    mRst    = en && !wClr && wStep && (mWdt == {WB{1'b1}});
    if (!en || wClr)  mWdt = '0;
    else if (wStep)   mWdt = mWdt + 1'b1;
    if (!wr && tTick && mTmr == 8'hFF) mOvf = 1'b1;
    else if (iClr)                      mOvf = 1'b0;
    if (wr)         mTmr = wrData;
    else if (tTick) mTmr = mTmr + 8'd1;
    if (wr || wClr) mPs = '0;
    else if (psInc) mPs = mPs + 8'd1;
    if (!sleep) mDiv = mDiv + 2'd1;
    mS3 = mS2; mS2 = mS1; mS1 = pin;
  endtask

  task automatic chk(input int act, input int exp, input string req, input string what);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compareAll(input string tag);
    chk(int'(tmrOut), int'(mTmr), tag, "timer");
    chk(int'(ovfOut), int'(mOvf), "R7", "flag");
    chk(int'(rstOut), int'(mRst), "R8", "wdtRst");
  endtask

  task automatic runPhase(input string tag, input int mode, input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      compareAll(tag);
      sleep = 0; div4 = 0; ext = 0; fall = 0; psaW = 1; ratio = 0;
      en = 0; wTick = 0; wClr = 0; wr = 0; iClr = 0;
      case (mode)
        1: begin // R1 divider options
          div4 = ((c / 40) % 2) == 1;
        end
        2: begin // R2 sleep freezes the timer, watchdog keeps going
          sleep = ((c / 10) % 2) == 1; en = 1; ratio = 3'd1; wTick = $urandom % 2;
          div4 = ((c / 50) % 2) == 1;
        end
        3: begin // R3 external edges through the synchronizer
          ext = 1; fall = ((c / 60) % 2) == 1; sleep = ($urandom % 4) == 0;
          if ($urandom % 3 == 0) pin = ~pin;
        end
        4: begin // R4 timer prescale ratios
          psaW = 0; ratio = 3'(c / 300);
          if ($urandom % 97 == 0) begin wr = 1; wrData = 8'($urandom); end
        end
        5: begin // R5 watchdog prescale ratios
          ratio = 3'(c / 100); en = 1; wTick = $urandom % 2;
        end
        6: begin // R6 loads against increments
          psaW = $urandom % 2; ratio = 3'($urandom % 3);
          if ($urandom % 5 == 0) begin wr = 1; wrData = 8'($urandom); end
        end
        7: begin // R7 overflow and clear collisions
          iClr = ($urandom % 4) == 0;
          if ($urandom % 12 == 0) begin wr = 1; wrData = ($urandom % 2) ? 8'hFE : 8'hFF; end
        end
        8: begin // R8 time-outs, half of them in sleep
          en = 1; wTick = 1; sleep = ((c / 10) % 2) == 1;
        end
        9: begin // R9 enable toggling
          en = ((c / 7) % 3) != 0; wTick = 1;
        end
        10: begin // R10 clear strobes
          en = 1; wTick = 1; wClr = ($urandom % 6) == 0;
          psaW = ((c / 32) % 2) == 1; ratio = 3'($urandom % 3);
        end
        default: begin // random mix
          sleep = ($urandom % 5) == 0; div4 = $urandom % 2; ext = $urandom % 2;
          fall = $urandom % 2; psaW = $urandom % 2; ratio = 3'($urandom % 4);
          en = ($urandom % 4) != 0; wTick = $urandom % 2; wClr = ($urandom % 20) == 0;
          iClr = ($urandom % 6) == 0;
          if ($urandom % 2 == 0) pin = ~pin;
          if ($urandom % 15 == 0) begin wr = 1; wrData = 8'($urandom); end
        end
      endcase
      modelStep();
    end
  endtask

  initial begin
    void'($urandom(32'd20240613));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(int'(tmrOut), 0, "R11", "timer");
    chk(int'(ovfOut), 0, "R11", "flag");
    chk(int'(rstOut), 0, "R11", "wdtRst");
    rstN = 1'b1;
    modelStep();
    runPhase("R1", 1, 160);
    runPhase("R2", 2, 200);
    runPhase("R3", 3, 400);
    runPhase("R4", 4, 2400);
    runPhase("R5", 5, 800);
    runPhase("R6", 6, 400);
    runPhase("R7", 7, 1500);
    runPhase("R8", 8, 300);
    runPhase("R9", 9, 300);
    runPhase("R10", 10, 400);
    runPhase("R3", 0, 3000);
    @(negedge clk);
    compareAll("R1");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

endmodule